// File: doc/BRIEF.md
# AC-link Capture Frame Serializer

This block is the codec-side transmitter of an AC'97-style serial link. It runs on the link bit clock and watches the frame strobe (`sync`) from the controller. It samples the strobe on falling edges. A low-to-high change of the strobe marks the start of a frame. On the next rising edge the block starts to shift out a 256-bit capture frame on `sdata_in`, one bit per rising edge, so that the controller can sample each bit on the falling edge that follows.

The frame has a 16-bit tag slot followed by twelve 20-bit slots, each sent MSB first. The tag slot carries the codec-ready flag and one valid flag per data slot. Slot 1 echoes a register index together with variable-rate request bits. Slot 2 returns register read data. Slots 3 and 4 carry the left and right capture samples. Slots 5 to 12 carry an auxiliary payload. A slot whose tag is clear is sent as all zeros, and every reserved bit is zero. All parallel inputs are captured at the start of each frame, so a frame is internally consistent however the inputs move while it is being sent.

The sequencer has four states. `ST_IDLE` is the state after reset, before any frame start. `ST_TAG` sends the tag slot. `ST_DATA` sends slots 1 to 12. `ST_GAP` is the state after a finished frame while no new start has arrived. The transitions are: a frame start moves any state to `ST_TAG`; the last tag bit moves `ST_TAG` to `ST_DATA`; the last bit of slot 12 moves `ST_DATA` to `ST_GAP`. Every other case holds the state. The line is driven only in `ST_TAG` and `ST_DATA`.

Top module: `acl_in_serializer`

## Requirements
- R1: While `rst_n` is low, and from reset release until the first detected frame start, `sdata_in` is 0.
- R2: If `sync` rises after rising edge k and is seen high at falling edge k with the previous falling-edge sample low, then the tag MSB (codec ready) is on `sdata_in` from rising edge k+1.
- R3: A frame is 256 bits, one new bit per rising edge. The order is the tag slot and then slots 1 to 12. When the next start arrives at the falling edge that samples bit 255, the next frame's bit 0 follows bit 255 with no gap.
- R4: Tag slot bits (MSB = bit 15): bit 15 is `codec_ready`; bit 15−s is `slot_valid[s-1]` for s = 1..12; bits 2:0 are 0.
- R5: Slot 1 bits (MSB = bit 19): bit 19 is 0; bits 18:12 are `reg_index`; bits 11:2 are `slot_req`; bits 1:0 are 0.
- R6: Slot 2 bits: bits 19:4 are `reg_rdata` and bits 3:0 are 0.
- R7: Slots 3 and 4 carry `pcm_left` and `pcm_right` MSB-aligned in bits 19 downward; the 20−PCM_W trailing bits are 0.
- R8: Slot s for s = 5..12 carries `aux_data[20*(s-5)+19 : 20*(s-5)]`, MSB first.
- R9: A data slot whose `slot_valid` flag was 0 at frame start is sent as 20 zero bits, whatever its data inputs hold.
- R10: Input changes after a frame has started have no effect on the bits of that frame.
- R11: After bit 255, if no new frame start has been seen, `sdata_in` stays 0 until the next start.
- R12: A frame start detected in the middle of a frame abandons that frame. The new frame's bit 0 is sent on the next rising edge.
- R13: `sync` held high over many bit clocks produces only one frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Link bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | input | 1 | Frame strobe from the controller, changes on rising edges |
| codec_ready | input | 1 | Codec-ready flag for tag bit 15 |
| slot_valid | input | NUM_SLOTS | Valid flag per data slot, bit 0 for slot 1 |
| reg_index | input | IDX_W | Register index echoed in slot 1 |
| slot_req | input | REQ_W | Variable-rate request bits for slot 1 |
| reg_rdata | input | RD_W | Register read data for slot 2 |
| pcm_left | input | PCM_W | Left capture sample for slot 3 |
| pcm_right | input | PCM_W | Right capture sample for slot 4 |
| aux_data | input | (NUM_SLOTS-4)*SLOT_W | Payload for slots 5 to 12, slot 5 in the low 20 bits |
| sdata_in | output | 1 | Serial capture frame, changes on rising edges |

## Verification
The hardest situations to reach from the ports are the ones where a frame start coincides with a frame boundary or cuts into a frame. These are the back-to-back start sampled on the same falling edge as bit 255, and a restart at bit 60. The bench reaches both by counting falling-edge samples inside each frame and raising `sync` half a cycle before the falling edge that must detect it. It loads the next pattern at that same moment, so that the latching order is also tested. A held-high strobe and a mid-frame inversion of every input complete the timing corners. Walking, all-set, all-clear and all-ones tag and data patterns sweep the slot layouts.

// File: rtl/acl_pkg.sv
package acl_pkg;

    // Sequencer states of the capture-frame transmitter
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // after reset, no frame start seen yet
        ST_TAG  = 2'd1,   // shifting the tag slot
        ST_DATA = 2'd2,   // shifting data slots 1..N
        ST_GAP  = 2'd3    // frame finished, waiting for next start
    } acl_state_e;

endpackage

// File: rtl/acl_sync_edge.sv
module acl_sync_edge (
    input  logic bit_clk,
    input  logic rst_n,
    input  logic sync,
    output logic frame_start
);

    logic sync_prev;

    // The strobe is sampled on the falling edge; a start is a 0 -> 1 change
    // between two consecutive falling-edge samples.
    always_ff @(negedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_prev   <= 1'b0;
            frame_start <= 1'b0;
        end else begin
            sync_prev   <= sync;
            frame_start <= sync & ~sync_prev;
        end
    end

endmodule

// File: rtl/acl_slot_counter.sv
module acl_slot_counter #(
    parameter  int SLOT_W     = 20,
    parameter  int TAG_W      = 16,
    parameter  int NUM_SLOTS  = 12,
    localparam int SLOT_IDX_W = $clog2(NUM_SLOTS + 1),
    localparam int POS_W      = $clog2(SLOT_W)
) (
    input  logic                  bit_clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  advance,
    output logic [SLOT_IDX_W-1:0] slot,
    output logic [POS_W-1:0]      pos,
    output logic                  tag_done,
    output logic                  frame_done
);

    localparam logic [POS_W-1:0]      TAG_TOP  = POS_W'(TAG_W - 1);
    localparam logic [POS_W-1:0]      SLOT_TOP = POS_W'(SLOT_W - 1);
    localparam logic [SLOT_IDX_W-1:0] LAST_SL  = SLOT_IDX_W'(NUM_SLOTS);

    // slot: index of slot on the line; pos: bit number inside that slot,
    // counting down so that the MSB goes first.
    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            slot <= '0;
            pos  <= '0;
        end else if (load) begin
            slot <= '0;
            pos  <= TAG_TOP;
        end else if (advance) begin
            if (pos == '0) begin
                slot <= slot + 1'b1;
                pos  <= SLOT_TOP;
            end else begin
                pos  <= pos - 1'b1;
            end
        end
    end

    always_comb begin
        tag_done   = (slot == '0) && (pos == '0);
        frame_done = (slot == LAST_SL) && (pos == '0);
    end

endmodule

// File: rtl/acl_frame_fsm.sv
module acl_frame_fsm
    import acl_pkg::*;
(
    input  logic       bit_clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic       tag_done,
    input  logic       frame_done,
    output acl_state_e state,
    output logic       shifting,
    output logic       advance
);

    acl_state_e state_nx;

    // State register
    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions: a frame start wins from every state
    always_comb begin
        state_nx = state;
        if (frame_start) begin
            state_nx = ST_TAG;
        end else begin
            unique case (state)
                ST_IDLE: state_nx = ST_IDLE;
                ST_TAG:  state_nx = tag_done   ? ST_DATA : ST_TAG;
                ST_DATA: state_nx = frame_done ? ST_GAP  : ST_DATA;
                ST_GAP:  state_nx = ST_GAP;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // Outputs decoded from the state
    always_comb begin
        shifting = 1'b0;
        advance  = 1'b0;
        unique case (state)
            ST_IDLE: shifting = 1'b0;
            ST_TAG: begin
                shifting = 1'b1;
                advance  = 1'b1;
            end
            ST_DATA: begin
                shifting = 1'b1;
                advance  = !frame_done;
            end
            ST_GAP:  shifting = 1'b0;
            default: shifting = 1'b0;
        endcase
    end

endmodule

// File: rtl/acl_slot_formatter.sv
module acl_slot_formatter #(
    parameter  int SLOT_W     = 20,
    parameter  int TAG_W      = 16,
    parameter  int NUM_SLOTS  = 12,
    parameter  int PCM_W      = 18,
    parameter  int IDX_W      = 7,
    parameter  int REQ_W      = 10,
    parameter  int RD_W       = 16,
    localparam int AUX_N      = NUM_SLOTS - 4,
    localparam int SLOT_IDX_W = $clog2(NUM_SLOTS + 1),
    localparam int POS_W      = $clog2(SLOT_W)
) (
    input  logic                    ready,
    input  logic [NUM_SLOTS-1:0]    valid,
    input  logic [IDX_W-1:0]        idx,
    input  logic [REQ_W-1:0]        req,
    input  logic [RD_W-1:0]         rdata,
    input  logic [PCM_W-1:0]        pcm_l,
    input  logic [PCM_W-1:0]        pcm_r,
    input  logic [AUX_N*SLOT_W-1:0] aux,
    input  logic [SLOT_IDX_W-1:0]   slot,
    input  logic [POS_W-1:0]        pos,
    output logic                    bit_out
);

    // Trailing zero bits of each formatted slot
    localparam int S1_TAIL  = 2;
    localparam int S2_TAIL  = SLOT_W - RD_W;
    localparam int PCM_TAIL = SLOT_W - PCM_W;
    localparam int TAG_ZERO = TAG_W - 1 - NUM_SLOTS;

    logic [TAG_W-1:0]  tag;
    logic [SLOT_W-1:0] words [0:NUM_SLOTS];

    // Tag slot: ready flag at the top, then one flag per data slot
    assign tag[TAG_W-1]      = ready;
    assign tag[TAG_ZERO-1:0] = '0;

    for (genvar s = 1; s <= NUM_SLOTS; s++) begin : g_tag
        assign tag[TAG_W-1-s] = valid[s-1];
    end

    assign words[0] = SLOT_W'(tag);

    // Status address slot: zero MSB, index, request bits, zero tail
    assign words[1] = valid[0] ? (SLOT_W'({idx, req}) << S1_TAIL) : '0;

    // Status data slot: read data, zero tail
    assign words[2] = valid[1] ? (SLOT_W'(rdata) << S2_TAIL) : '0;

    // Capture samples, MSB aligned
    assign words[3] = valid[2] ? (SLOT_W'(pcm_l) << PCM_TAIL) : '0;
    assign words[4] = valid[3] ? (SLOT_W'(pcm_r) << PCM_TAIL) : '0;

    // Remaining slots take their payload from the auxiliary bus
    for (genvar a = 0; a < AUX_N; a++) begin : g_aux
        assign words[a+5] = valid[a+4] ? aux[a*SLOT_W +: SLOT_W] : '0;
    end

    always_comb begin
        if (slot <= SLOT_IDX_W'(NUM_SLOTS)) begin
            bit_out = words[slot][pos];
        end else begin
            bit_out = 1'b0;
        end
    end

endmodule

// File: rtl/acl_in_serializer.sv
module acl_in_serializer
    import acl_pkg::*;
#(
    parameter  int SLOT_W     = 20,
    parameter  int TAG_W      = 16,
    parameter  int NUM_SLOTS  = 12,
    parameter  int PCM_W      = 18,
    parameter  int IDX_W      = 7,
    parameter  int REQ_W      = 10,
    parameter  int RD_W       = 16,
    localparam int AUX_N      = NUM_SLOTS - 4,
    localparam int SLOT_IDX_W = $clog2(NUM_SLOTS + 1),
    localparam int POS_W      = $clog2(SLOT_W)
) (
    input  logic                    bit_clk,
    input  logic                    rst_n,
    input  logic                    sync,
    input  logic                    codec_ready,
    input  logic [NUM_SLOTS-1:0]    slot_valid,
    input  logic [IDX_W-1:0]        reg_index,
    input  logic [REQ_W-1:0]        slot_req,
    input  logic [RD_W-1:0]         reg_rdata,
    input  logic [PCM_W-1:0]        pcm_left,
    input  logic [PCM_W-1:0]        pcm_right,
    input  logic [AUX_N*SLOT_W-1:0] aux_data,
    output logic                    sdata_in
);

    logic                    frame_start;
    logic                    tag_done;
    logic                    frame_done;
    logic                    shifting;
    logic                    advance;
    logic                    fmt_bit;
    acl_state_e              fsm_state;
    logic [SLOT_IDX_W-1:0]   cur_slot;
    logic [POS_W-1:0]        cur_pos;

    // Frame snapshot, captured on the rising edge that starts a frame
    logic                    lat_ready;
    logic [NUM_SLOTS-1:0]    lat_valid;
    logic [IDX_W-1:0]        lat_idx;
    logic [REQ_W-1:0]        lat_req;
    logic [RD_W-1:0]         lat_rdata;
    logic [PCM_W-1:0]        lat_pcm_l;
    logic [PCM_W-1:0]        lat_pcm_r;
    logic [AUX_N*SLOT_W-1:0] lat_aux;

    acl_sync_edge u_sync (
        .bit_clk     (bit_clk),
        .rst_n       (rst_n),
        .sync        (sync),
        .frame_start (frame_start)
    );

    acl_frame_fsm u_fsm (
        .bit_clk     (bit_clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .tag_done    (tag_done),
        .frame_done  (frame_done),
        .state       (fsm_state),
        .shifting    (shifting),
        .advance     (advance)
    );

    acl_slot_counter #(
        .SLOT_W    (SLOT_W),
        .TAG_W     (TAG_W),
        .NUM_SLOTS (NUM_SLOTS)
    ) u_cnt (
        .bit_clk    (bit_clk),
        .rst_n      (rst_n),
        .load       (frame_start),
        .advance    (advance),
        .slot       (cur_slot),
        .pos        (cur_pos),
        .tag_done   (tag_done),
        .frame_done (frame_done)
    );

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_ready <= 1'b0;
            lat_valid <= '0;
            lat_idx   <= '0;
            lat_req   <= '0;
            lat_rdata <= '0;
            lat_pcm_l <= '0;
            lat_pcm_r <= '0;
            lat_aux   <= '0;
        end else if (frame_start) begin
            lat_ready <= codec_ready;
            lat_valid <= slot_valid;
            lat_idx   <= reg_index;
            lat_req   <= slot_req;
            lat_rdata <= reg_rdata;
            lat_pcm_l <= pcm_left;
            lat_pcm_r <= pcm_right;
            lat_aux   <= aux_data;
        end
    end

    acl_slot_formatter #(
        .SLOT_W    (SLOT_W),
        .TAG_W     (TAG_W),
        .NUM_SLOTS (NUM_SLOTS),
        .PCM_W     (PCM_W),
        .IDX_W     (IDX_W),
        .REQ_W     (REQ_W),
        .RD_W      (RD_W)
    ) u_fmt (
        .ready   (lat_ready),
        .valid   (lat_valid),
        .idx     (lat_idx),
        .req     (lat_req),
        .rdata   (lat_rdata),
        .pcm_l   (lat_pcm_l),
        .pcm_r   (lat_pcm_r),
        .aux     (lat_aux),
        .slot    (cur_slot),
        .pos     (cur_pos),
        .bit_out (fmt_bit)
    );

    // Registered state and counters change only on rising edges, so the
    // line does too; it is forced low outside the shifting states.
    assign sdata_in = shifting & fmt_bit;

endmodule

// File: rtl/acl_in_serializer_chk.sv
module acl_in_serializer_chk
    import acl_pkg::*;
#(
    parameter  int SLOT_W     = 20,
    parameter  int TAG_W      = 16,
    parameter  int NUM_SLOTS  = 12,
    localparam int SLOT_IDX_W = $clog2(NUM_SLOTS + 1),
    localparam int POS_W      = $clog2(SLOT_W)
) (
    input logic                  bit_clk,
    input logic                  rst_n,
    input logic                  sdata_in,
    input logic                  frame_start,
    input acl_state_e            state,
    input logic [SLOT_IDX_W-1:0] slot,
    input logic [POS_W-1:0]      pos,
    input logic [NUM_SLOTS-1:0]  lat_valid
);

    logic cur_valid;

    always_comb begin
        if (slot >= SLOT_IDX_W'(1) && slot <= SLOT_IDX_W'(NUM_SLOTS)) begin
            cur_valid = lat_valid[slot - 1'b1];
        end else begin
            cur_valid = 1'b1;
        end
    end

    // R2
    start_load_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        frame_start |=> (state == ST_TAG && slot == '0 && pos == POS_W'(TAG_W - 1)));

    // R1
    quiet_line_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_GAP) |-> !sdata_in);

    // R3
    slot_range_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        slot <= SLOT_IDX_W'(NUM_SLOTS));

    // R3
    bit_step_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (state == ST_DATA && !frame_start && pos != '0) |=> (pos == $past(pos) - 1'b1));

    // R11
    frame_end_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (state == ST_DATA && slot == SLOT_IDX_W'(NUM_SLOTS) && pos == '0 && !frame_start)
        |=> (state == ST_GAP));

    // R9
    invalid_zero_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (state == ST_DATA && !cur_valid) |-> !sdata_in);

    // R5
    status_pad_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (state == ST_DATA && slot == SLOT_IDX_W'(1) &&
         (pos == POS_W'(SLOT_W - 1) || pos < POS_W'(2))) |-> !sdata_in);

    // R13
    single_start_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

endmodule

bind acl_in_serializer acl_in_serializer_chk #(
    .SLOT_W    (SLOT_W),
    .TAG_W     (TAG_W),
    .NUM_SLOTS (NUM_SLOTS)
) u_chk (
    .bit_clk     (bit_clk),
    .rst_n       (rst_n),
    .sdata_in    (sdata_in),
    .frame_start (frame_start),
    .state       (fsm_state),
    .slot        (cur_slot),
    .pos         (cur_pos),
    .lat_valid   (lat_valid)
);

// File: tb/acl_in_serializer_bench.sv
module acl_in_serializer_bench;

    localparam int SW = 20;
    localparam int TW = 16;
    localparam int NS = 12;
    localparam int PW = 18;
    localparam int IW = 7;
    localparam int QW = 10;
    localparam int DW = 16;
    localparam int AN = NS - 4;
    localparam int FB = TW + NS * SW;

    logic           clk   = 1'b0;
    logic           rst_n = 1'b0;
    logic           sync  = 1'b0;
    logic           ready = 1'b0;
    logic [NS-1:0]  valid = '0;
    logic [IW-1:0]  idx   = '0;
    logic [QW-1:0]  req   = '0;
    logic [DW-1:0]  rdata = '0;
    logic [PW-1:0]  pl    = '0;
    logic [PW-1:0]  pr    = '0;
    logic [AN*SW-1:0] aux = '0;
    logic           sdata;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [FB-1:0] exp_frame = '0;

    always #10 clk = ~clk;

    acl_in_serializer u_acl_in_serializer (
        .bit_clk     (clk),
        .rst_n       (rst_n),
        .sync        (sync),
        .codec_ready (ready),
        .slot_valid  (valid),
        .reg_index   (idx),
        .slot_req    (req),
        .reg_rdata   (rdata),
        .pcm_left    (pl),
        .pcm_right   (pr),
        .aux_data    (aux),
        .sdata_in    (sdata)
    );

    task automatic check_bit(input string tag, input int i, input logic act, input logic expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s bit %0d: actual %b expected %b", tag, i, act, expv);
        end
    endtask

    // Expected frame from the slot layouts in the requirements (R4..R9)
    function automatic logic [FB-1:0] build_frame();
        logic [FB-1:0] f;
        logic [TW-1:0] t;
        logic [SW-1:0] w;
        t = '0;
        t[TW-1] = ready;
        for (int s = 1; s <= NS; s++) t[TW-1-s] = valid[s-1];
        f = '0;
        f[FB-1 -: TW] = t;
        for (int s = 1; s <= NS; s++) begin
            if (s == 1)      w = {1'b0, idx, req, 2'b00};
            else if (s == 2) w = {rdata, 4'b0000};
            else if (s == 3) w = {pl, 2'b00};
            else if (s == 4) w = {pr, 2'b00};
            else             w = aux[(s-5)*SW +: SW];
            if (!valid[s-1]) w = '0;
            f[FB-1-TW-(s-1)*SW -: SW] = w;
        end
        return f;
    endfunction

    task automatic apply_pattern(input int k);
        if (k < NS)       valid = NS'(1) << k;
        else if (k == 12) valid = '1;
        else if (k == 13) valid = '0;
        else if (k == 14) valid = '1;
        else              valid = NS'(k * 1443 + 7);
        ready = ((k % 3) != 0);
        idx   = IW'(k * 37 + 5);
        req   = QW'(k * 291 + 3);
        rdata = DW'(k * 4099 + 165);
        pl    = PW'(k * 7919 + 1);
        pr    = PW'(k * 104729 + 77);
        for (int s = 0; s < AN; s++) aux[s*SW +: SW] = SW'(k * 131 + s * 977 + 1);
        if (k == 14) begin
            idx = '1; req = '1; rdata = '1; pl = '1; pr = '1; aux = '1;
        end
        exp_frame = build_frame();
    endtask

    task automatic scramble();
        ready = ~ready; valid = ~valid; idx = ~idx; req = ~req;
        rdata = ~rdata; pl = ~pl; pr = ~pr; aux = ~aux;
    endtask

    function automatic string tag_for(input int i, input logic [NS-1:0] v);
        int s;
        if (i < TW) return (i == 0) ? "R2" : "R4";
        s = (i - TW) / SW + 1;
        if (!v[s-1]) return "R9";
        if (s == 1)  return "R5";
        if (s == 2)  return "R6";
        if (s <= 4)  return "R7";
        return "R8";
    endfunction

    task automatic start_frame(input int k);
        apply_pattern(k);
        @(posedge clk);
        #2 sync = 1'b1;
        @(negedge clk);
    endtask

    // Samples bits 0..last_i on falling edges after the detecting edge
    task automatic run_frame(input int last_i, input bit chain, input int next_k,
                             input bit scram, input bit hold, input string first_tag);
        logic [FB-1:0] e;
        logic [NS-1:0] v;
        e = exp_frame;
        v = valid;
        for (int i = 0; i <= last_i; i++) begin
            string t;
            @(negedge clk);
            if (i == 0)                t = first_tag;
            else if (scram && i > 100) t = "R10";
            else                       t = tag_for(i, v);
            check_bit(t, i, sdata, e[FB-1-i]);
            #5;
            if (i == 15 && !hold) sync = 1'b0;
            if (scram && i == 100) scramble();
            if (chain && i == last_i - 1) begin
                apply_pattern(next_k);
                sync = 1'b1;
            end
        end
    endtask

    task automatic gap_check(input int n, input string tag);
        for (int g = 0; g < n; g++) begin
            @(negedge clk);
            check_bit(tag, g, sdata, 1'b0);
            #5 sync = 1'b0;
        end
    endtask

    initial begin
        // R1: reset and pre-start quiet line
        ready = 1'b1; valid = '1; idx = '1; rdata = '1; pl = '1;
        for (int r = 0; r < 3; r++) begin
            @(negedge clk);
            check_bit("R1", r, sdata, 1'b0);
        end
        #5 rst_n = 1'b1;
        gap_check(4, "R1");

        // R10: inputs inverted in the middle of a frame
        start_frame(0);
        run_frame(FB - 1, 1'b0, 0, 1'b1, 1'b0, "R2");
        gap_check(4, "R11");

        // R3..R9: back-to-back frames over a sweep of tag and data patterns
        start_frame(1);
        for (int k = 1; k <= 14; k++) begin
            run_frame(FB - 1, (k < 14), k + 1, 1'b0, 1'b0, (k == 1) ? "R2" : "R3");
        end
        gap_check(4, "R11");

        // R13: strobe held high through a whole frame
        start_frame(15);
        run_frame(FB - 1, 1'b0, 0, 1'b0, 1'b1, "R2");
        gap_check(6, "R13");

        // R12: new start in the middle of a frame
        start_frame(16);
        run_frame(60, 1'b1, 17, 1'b0, 1'b0, "R2");
        run_frame(FB - 1, 1'b0, 0, 1'b0, 1'b0, "R12");
        gap_check(4, "R11");

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual running expected done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule